// File: doc/BRIEF.md
# Byte-Strobed Write Memory

This block is the write side of a small byte-addressable memory that sits behind a 128-bit write data channel with one strobe bit per byte lane. On every accepted beat it takes a byte address, a transfer size, a strobe and the data. It then updates only the bytes of the addressed 16-byte word whose lanes are both strobed and legal for that size and address.

Strobe bits that fall outside the lanes the transfer size allows are dropped instead of trusted. A sticky flag records that this happened and stays set until reset. A combinational read port returns any stored word, so the results of writes can be inspected. Address and response handshakes and multi-beat bursts are handled elsewhere.

Top module: `strb_wr_mem`

## Requirements
- R1: On an accepted beat, only the bytes whose effective strobe bit is 1 change. Every other byte of the target word, and every other word, keeps its previous value.
- R2: Strobe bit n selects data bits [8n+7:8n] and byte offset n of the word indexed by wr_addr[ADDR_W-1:4]. Byte offset n sits at bits [8n+7:8n] of rd_data.
- R3: A size-1 beat at byte offset 0 with strobe 0x0003 and the same value on both low lanes writes that value into bytes 0 and 1.
- R4: The legal window is 2^wr_size bytes. It starts at wr_addr[3:0] rounded down to a multiple of 2^wr_size. Any wr_size of 4 or more covers all 16 lanes. The effective strobe is wr_strb ANDed with the window, and lanes outside the window are never written.
- R5: strb_err becomes 1 after any accepted beat whose wr_strb has a bit outside the window. Once set, it stays 1 until reset.
- R6: While reset is active (rst_n low), all memory words read 0 and strb_err is 0. A beat with every strobe bit inside its window leaves strb_err unchanged.
- R7: A beat with wr_strb equal to 0 is accepted, changes no memory and does not set strb_err.
- R8: rd_data is the word at rd_addr, combinationally. A read in the cycle after a write returns the updated bytes.
- R9: A write happens only on a rising clock edge where wr_valid and wr_ready are both 1, using the strobe and data present at that edge. wr_ready is always 1. With wr_valid at 0, nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Beat present |
| wr_ready | output | 1 | Beat accepted (always 1) |
| wr_addr | input | ADDR_W (8) | Byte address of the beat |
| wr_size | input | 3 | Log2 of transfer bytes |
| wr_strb | input | LANES (16) | Per-lane write enables |
| wr_data | input | DATA_W (128) | Write data, lane n at [8n+7:8n] |
| rd_addr | input | WORD_W (4) | Word index to read |
| rd_data | output | DATA_W (128) | Stored word at rd_addr |
| strb_err | output | 1 | Sticky out-of-window strobe flag |

## Verification
A wrongly computed window or lane enable corrupts a byte in storage. That byte shows up at rd_data as soon as its word is read, which is the next cycle when the bench points rd_addr at the written word. A lost or spurious error bit appears on strb_err one cycle after the offending beat. Because the flag is sticky, a wrong setting also persists until the next reset, so a per-cycle comparison against a behavioural model catches it on the first divergent edge.

// File: rtl/strb_wr_mem.sv
module strb_wr_mem #(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 16
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           wr_valid,
  output logic                                           wr_ready,
  input  logic [$clog2(DEPTH)+$clog2(DATA_W/8)-1:0]      wr_addr,
  input  logic [2:0]                                     wr_size,
  input  logic [DATA_W/8-1:0]                            wr_strb,
  input  logic [DATA_W-1:0]                              wr_data,
  input  logic [$clog2(DEPTH)-1:0]                       rd_addr,
  output logic [DATA_W-1:0]                              rd_data,
  output logic                                           strb_err
);
  localparam int LANES  = DATA_W / 8;
  localparam int LB     = $clog2(LANES);
  localparam int WORD_W = $clog2(DEPTH);
  localparam int ADDR_W = WORD_W + LB;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LB:0]       nbytes;
  logic [LB-1:0]     off;
  logic [LANES-1:0]  win, eff;
  logic [DATA_W-1:0] win_bits;
  logic [WORD_W-1:0] wa;
  logic              fire;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid & wr_ready;
  assign wa       = wr_addr[ADDR_W-1:LB];
  assign rd_data  = mem[rd_addr];

  always_comb begin
    nbytes = (int'(wr_size) >= LB) ? (LB+1)'(LANES) : ((LB+1)'(1) << wr_size);
    off    = wr_addr[LB-1:0] & ~(nbytes[LB-1:0] - 1'b1);
    for (int i = 0; i < LANES; i++)
      win[i] = ((LB+1)'(i) >= {1'b0, off}) && ((LB+1)'(i) < ({1'b0, off} + nbytes));
  end

  assign eff = wr_strb & win;

  for (genvar g = 0; g < LANES; g++) begin : g_wbits
    assign win_bits[8*g +: 8] = {8{win[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      strb_err <= 1'b0;
    end else if (fire) begin
      for (int i = 0; i < LANES; i++)
        if (eff[i]) mem[wa][8*i +: 8] <= wr_data[8*i +: 8];
      if (|(wr_strb & ~win)) strb_err <= 1'b1;
    end
  end

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb_err |=> strb_err);

  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && |(wr_strb & ~win)) |=> strb_err);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (rd_addr != $past(rd_addr)) || $stable(rd_data));

  p_zero_strb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_strb == '0) |=> ((rd_addr != $past(rd_addr)) || $stable(rd_data)) &&
                                (strb_err == $past(strb_err)));

  p_outside_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rd_addr == wa) |=> (rd_addr != $past(rd_addr)) ||
      (((rd_data ^ $past(rd_data)) & ~$past(win_bits)) == '0));
endmodule

// File: tb/test_strb_wr_mem.sv
module test_strb_wr_mem;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [7:0]   wr_addr = '0;
  logic [2:0]   wr_size = '0;
  logic [15:0]  wr_strb = '0;
  logic [127:0] wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [127:0] rd_data;
  logic         strb_err;

  int compared = 0, mismatched = 0;
  bit monitor_on = 1'b0;

  logic [127:0] model [16];
  bit           ref_err;

  always #2.5 clk = ~clk;

  strb_wr_mem i_strb_wr_mem (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_strb(wr_strb), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .strb_err(strb_err));

  // Behavioural reference: window from size/address, lanes checked one by one.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 16; w++) model[w] = '0;
      ref_err = 1'b0;
    end else if (wr_valid) begin
      int nb, base;
      nb   = (wr_size >= 4) ? 16 : (1 << wr_size);
      base = ((wr_addr % 16) / nb) * nb;
      for (int l = 0; l < 16; l++)
        if (wr_strb[l]) begin
          if (l >= base && l < base + nb) model[wr_addr / 16][8*l +: 8] = wr_data[8*l +: 8];
          else ref_err = 1'b1;
        end
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle comparison covering R1 R2 R4 R5 R8
  always @(negedge clk) begin
    #1;
    if (monitor_on && rst_n) begin
      chk("R1/R8 per-cycle read", rd_data, model[rd_addr]);
      chk("R5 per-cycle flag", {127'b0, strb_err}, {127'b0, ref_err});
    end
  end

  task automatic beat(input logic v, input logic [7:0] a, input logic [2:0] s,
                      input logic [15:0] st, input logic [127:0] d);
    wr_valid = v; wr_addr = a; wr_size = s; wr_strb = st; wr_data = d;
    rd_addr = a[7:4];
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1;
    chk("R6 reset data", rd_data, '0);
    chk("R6 reset flag", {127'b0, strb_err}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    @(negedge clk);

    beat(1, 8'h00, 3'd1, 16'h0001, 128'h02);
    chk("R2 lane 0", rd_data, 128'h02);
    beat(1, 8'h00, 3'd1, 16'h0002, 128'h0200);
    chk("R2 lane 1", rd_data, 128'h0202);
    beat(1, 8'h10, 3'd1, 16'h0003, 128'h0303);
    chk("R3 two low lanes", rd_data, 128'h0303);
    chk("R6 legal leaves flag", {127'b0, strb_err}, '0);
    beat(1, 8'h00, 3'd4, 16'h0000, {128{1'b1}});
    chk("R7 zero strobe data", rd_data, 128'h0202);
    chk("R7 zero strobe flag", {127'b0, strb_err}, '0);
    beat(0, 8'h00, 3'd4, 16'hFFFF, {128{1'b1}});
    chk("R9 valid low", rd_data, 128'h0202);
    beat(1, 8'h20, 3'd4, 16'hFFFF, 128'h0f0e0d0c0b0a09080706050403020100);
    chk("R8 full word", rd_data, 128'h0f0e0d0c0b0a09080706050403020100);
    beat(1, 8'h24, 3'd2, 16'h00F0, {128{1'b1}});
    chk("R1 partial keeps others", rd_data, 128'h0f0e0d0c0b0a0908ffffffff03020100);
    beat(1, 8'h30, 3'd0, 16'h0003, {16{8'hAA}});
    chk("R4 clip to one lane", rd_data, 128'hAA);
    chk("R5 flag set", {127'b0, strb_err}, 128'h1);
    beat(1, 8'h36, 3'd2, 16'h0FF0, {16{8'h55}});
    chk("R4 aligned window", rd_data, 128'h00000000000000005555555500000000 | 128'hAA);
    chk("R5 flag sticky", {127'b0, strb_err}, 128'h1);

    for (int k = 0; k < 400; k++) begin
      wr_valid = 1'($urandom_range(0, 1));
      wr_addr  = 8'($urandom);
      wr_size  = 3'($urandom);
      wr_strb  = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      wr_data  = {$urandom, $urandom, $urandom, $urandom};
      rd_addr  = ($urandom_range(0, 1) == 1) ? wr_addr[7:4] : 4'($urandom);
      @(negedge clk);
    end
    wr_valid = 1'b0;

    monitor_on = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R6 reset clears flag", {127'b0, strb_err}, '0);
    rd_addr = 4'd2;
    #1;
    chk("R6 reset clears memory", rd_data, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule